// File: doc/BRIEF.md
# Bidirectional Latch-or-Register Bus Transceiver

This block joins two data buses, A and B, through two independent one-way paths: A towards B and B towards A. The data width is split into channels (by default two channels of 9 bits). Each channel has a full control set for each direction: an active-low output enable, a latch enable and a path clock. The same part can therefore serve as two narrow transceivers or, with the controls tied together, as one wide transceiver.

Each path holds one storage element that acts either as a transparent latch or as a rising-edge register. While the latch enable is high the path is transparent and its output follows its input in the same cycle. While the latch enable is low the path keeps its stored word, and a rising edge of the path clock loads the current input. The path clock is a level input sampled by the core clock `clk`, so an edge counts when the level was low at one `clk` edge and is high at the next. Tri-state pins are represented by a data output plus a drive-enable output for each channel and direction. Merging both directions of a channel onto one shared pin is left to the integrator.

Top module: `ubt_xcvr`

## Requirements
- R1: While `rst_n` is low every stored word is zero and every path-clock history is low, so a path with latch enable low outputs all zeros.
- R2: When a path's latch enable is high, the output slice of that path equals its input slice in the same cycle, with no clock edge needed.
- R3: When a path's latch enable is low and no rising path-clock edge is seen (clock held low, held high, or falling), the stored word does not change and the output keeps its previous value.
- R4: When latch enable is low and the path clock is low at one `clk` edge and high at the next, that edge loads the input. From that edge on, the output shows the input sampled there.
- R5: While latch enable is high, each `clk` edge loads the input into storage. After latch enable falls, the output holds the input that was present at the last `clk` edge with latch enable high.
- R6: A path's drive-enable output is 1 exactly when its active-low output enable is 0. The enable only gates driving: it changes neither the stored word nor the data output.
- R7: The B-to-A path follows R2 to R6 using only its own enable, latch enable and clock, and it is unaffected by the A-to-B controls.
- R8: Each channel's slice (channel k owns bits k*9 through k*9+8 by default) responds only to that channel's own control bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; samples the path clocks and updates the storage |
| rst_n | input | 1 | Asynchronous active-low reset |
| a_i | input | NCH*CH_W | Bus A input data |
| b_i | input | NCH*CH_W | Bus B input data |
| ab_oe_n | input | NCH | A-to-B output enable per channel, active low |
| ab_le | input | NCH | A-to-B latch enable per channel |
| ab_ck | input | NCH | A-to-B path clock level per channel |
| ba_oe_n | input | NCH | B-to-A output enable per channel, active low |
| ba_le | input | NCH | B-to-A latch enable per channel |
| ba_ck | input | NCH | B-to-A path clock level per channel |
| b_o | output | NCH*CH_W | Data presented towards bus B |
| b_oe | output | NCH | Drive-enable for bus B per channel |
| a_o | output | NCH*CH_W | Data presented towards bus A |
| a_oe | output | NCH | Drive-enable for bus A per channel |

## Verification
Transparent data (R2) and drive enables (R6) are combinational and are due in the same cycle as their inputs. The bench checks them 1 ns after it drives the inputs at the falling edge. Loads (R4, R5) appear after exactly one rising `clk` edge, so the bench updates its own model at that edge and compares again at the following falling edge. Holds (R3) are checked at both sample points across several cycles with the input changing. The path-clock history is modelled so that an edge counts only across two consecutive `clk` edges, which is the same single-register delay the design has.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

    typedef enum logic [1:0] {
        MODE_PASS = 2'd0,
        MODE_HOLD = 2'd1,
        MODE_LOAD = 2'd2
    } path_mode_e;

    function automatic path_mode_e ubt_decode(input logic le, input logic rise);
        if (le)        return MODE_PASS;
        else if (rise) return MODE_LOAD;
        else           return MODE_HOLD;
    endfunction

endpackage

// File: rtl/ubt_path.sv
module ubt_path
    import ubt_pkg::*;
#(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din_i,
    input  logic         le_i,
    input  logic         ck_i,
    input  logic         oe_n_i,
    output logic [W-1:0] dout_o,
    output logic         oe_o
);

    typedef struct packed {
        logic [W-1:0] hold;
        logic         ck_prev;
    } path_st_t;

    path_st_t   st_d, st_q;
    path_mode_e mode;
    logic       rise;

    always_comb begin
        rise = ck_i & ~st_q.ck_prev;
        mode = ubt_decode(le_i, rise);
        st_d = st_q;
        st_d.ck_prev = ck_i;
        case (mode)
            MODE_PASS, MODE_LOAD: st_d.hold = din_i;
            default:              st_d.hold = st_q.hold;
        endcase
        dout_o = (mode == MODE_PASS) ? din_i : st_q.hold;
        oe_o   = ~oe_n_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    a_r1_reset_clear: assert property (@(posedge clk)
        !rst_n |=> st_q.hold == '0);

    a_r3_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_i && !(ck_i && !st_q.ck_prev)) |=> $stable(st_q.hold));

    a_r4_edge_load: assert property (@(posedge clk) disable iff (!rst_n)
        (!le_i && ck_i && !st_q.ck_prev) |=> st_q.hold == $past(din_i));

    a_r5_track_open: assert property (@(posedge clk) disable iff (!rst_n)
        le_i |=> st_q.hold == $past(din_i));

    a_r5_close_keeps: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(le_i) && $past(rst_n)) |-> dout_o == $past(din_i));

endmodule

// File: rtl/ubt_channel.sv
module ubt_channel #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] a_i,
    input  logic [W-1:0] b_i,
    input  logic         ab_oe_n,
    input  logic         ab_le,
    input  logic         ab_ck,
    input  logic         ba_oe_n,
    input  logic         ba_le,
    input  logic         ba_ck,
    output logic [W-1:0] b_o,
    output logic         b_oe,
    output logic [W-1:0] a_o,
    output logic         a_oe
);

    ubt_path #(.W(W)) u_ab (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (a_i),
        .le_i   (ab_le),
        .ck_i   (ab_ck),
        .oe_n_i (ab_oe_n),
        .dout_o (b_o),
        .oe_o   (b_oe)
    );

    ubt_path #(.W(W)) u_ba (
        .clk    (clk),
        .rst_n  (rst_n),
        .din_i  (b_i),
        .le_i   (ba_le),
        .ck_i   (ba_ck),
        .oe_n_i (ba_oe_n),
        .dout_o (a_o),
        .oe_o   (a_oe)
    );

    a_r6_enable_follows: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ab_oe_n) |-> !b_oe);

endmodule

// File: rtl/ubt_xcvr.sv
module ubt_xcvr #(
    parameter int NCH  = 2,
    parameter int CH_W = 9,
    localparam int DW  = NCH * CH_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [DW-1:0]   a_i,
    input  logic [DW-1:0]   b_i,
    input  logic [NCH-1:0]  ab_oe_n,
    input  logic [NCH-1:0]  ab_le,
    input  logic [NCH-1:0]  ab_ck,
    input  logic [NCH-1:0]  ba_oe_n,
    input  logic [NCH-1:0]  ba_le,
    input  logic [NCH-1:0]  ba_ck,
    output logic [DW-1:0]   b_o,
    output logic [NCH-1:0]  b_oe,
    output logic [DW-1:0]   a_o,
    output logic [NCH-1:0]  a_oe
);

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        ubt_channel #(.W(CH_W)) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .a_i     (a_i[g*CH_W +: CH_W]),
            .b_i     (b_i[g*CH_W +: CH_W]),
            .ab_oe_n (ab_oe_n[g]),
            .ab_le   (ab_le[g]),
            .ab_ck   (ab_ck[g]),
            .ba_oe_n (ba_oe_n[g]),
            .ba_le   (ba_le[g]),
            .ba_ck   (ba_ck[g]),
            .b_o     (b_o[g*CH_W +: CH_W]),
            .b_oe    (b_oe[g]),
            .a_o     (a_o[g*CH_W +: CH_W]),
            .a_oe    (a_oe[g])
        );
    end

endmodule

// File: tb/tb_ubt_xcvr.sv
`timescale 1ns/1ps
module tb_ubt_xcvr;
    localparam int NCH = 2;
    localparam int CW  = 9;
    localparam int DW  = NCH * CW;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [DW-1:0]  a_i = '0, b_i = '0;
    logic [NCH-1:0] ab_oe_n = '1, ab_le = '0, ab_ck = '0;
    logic [NCH-1:0] ba_oe_n = '1, ba_le = '0, ba_ck = '0;
    logic [DW-1:0]  b_o, a_o;
    logic [NCH-1:0] b_oe, a_oe;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [CW-1:0] m_ab [NCH];
    logic [CW-1:0] m_ba [NCH];
    logic          p_ab [NCH];
    logic          p_ba [NCH];

    always #2 clk = ~clk;

    ubt_xcvr #(.NCH(NCH), .CH_W(CW)) dut (
        .clk(clk), .rst_n(rst_n), .a_i(a_i), .b_i(b_i),
        .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_ck(ab_ck),
        .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_ck(ba_ck),
        .b_o(b_o), .b_oe(b_oe), .a_o(a_o), .a_oe(a_oe)
    );

    function automatic string data_tag(string t, logic le);
        if (t != "") return t;
        return le ? "R2" : "R3/R4";
    endfunction

    task automatic cmp(string req, int ch, string what, logic [CW-1:0] act, logic [CW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s ch%0d %s: actual %h expected %h", req, ch, what, act, exp);
        end
    endtask

    task automatic check_all(string t);
        for (int c = 0; c < NCH; c++) begin
            cmp(data_tag(t, ab_le[c]), c, "b_o", b_o[c*CW +: CW],
                ab_le[c] ? a_i[c*CW +: CW] : m_ab[c]);
            cmp(t == "" ? "R7" : t, c, "a_o", a_o[c*CW +: CW],
                ba_le[c] ? b_i[c*CW +: CW] : m_ba[c]);
            cmp("R6", c, "b_oe", {8'd0, b_oe[c]}, {8'd0, ~ab_oe_n[c]});
            cmp("R6", c, "a_oe", {8'd0, a_oe[c]}, {8'd0, ~ba_oe_n[c]});
            cmp("R6", c, "shared-pin contention", {8'd0, a_oe[c] & b_oe[c]}, 9'd0);
        end
    endtask

    task automatic model_edge();
        for (int c = 0; c < NCH; c++) begin
            if (!rst_n) begin
                m_ab[c] = '0; m_ba[c] = '0; p_ab[c] = 1'b0; p_ba[c] = 1'b0;
            end else begin
                if (ab_le[c] || (ab_ck[c] && !p_ab[c])) m_ab[c] = a_i[c*CW +: CW];
                if (ba_le[c] || (ba_ck[c] && !p_ba[c])) m_ba[c] = b_i[c*CW +: CW];
                p_ab[c] = ab_ck[c];
                p_ba[c] = ba_ck[c];
            end
        end
    endtask

    task automatic cycle(string t);
        #1 check_all(t);
        @(posedge clk);
        model_edge();
        @(negedge clk);
        check_all(t);
    endtask

    task automatic rand_oe(int c);
        int r = $urandom % 3;
        ab_oe_n[c] = (r != 1);
        ba_oe_n[c] = (r != 2);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int c = 0; c < NCH; c++) begin
            m_ab[c] = '0; m_ba[c] = '0; p_ab[c] = 1'b0; p_ba[c] = 1'b0;
        end
        a_i = 18'h2AB5C; b_i = 18'h13579;
        repeat (3) @(posedge clk);
        @(negedge clk);
        #1 check_all("R1");
        rst_n = 1'b1;

        // R2 then R5: open both paths, then close with new data on the close cycle
        ab_le = '1; ba_le = '1; ab_oe_n = 2'b10; ba_oe_n = 2'b01;
        a_i = 18'h1F0F3; b_i = 18'h0A5A5;
        cycle("R2");
        a_i = 18'h3C3C3; b_i = 18'h2D2D2;
        cycle("R2");
        ab_le = '0; ba_le = '0;
        a_i = 18'h00111; b_i = 18'h3FFFE;
        cycle("R5");

        // R3: path clocks held high, input changing, no load
        ab_ck = '1; ba_ck = '1;
        cycle("R4");
        for (int k = 0; k < 4; k++) begin
            a_i = 18'(k * 18'h0F1E3 + 5); b_i = 18'(k * 18'h1234B + 9);
            cycle("R3");
        end
        // R3: falling path clock does not load
        ab_ck = '0; ba_ck = '0; a_i = 18'h15555; b_i = 18'h2AAAA;
        cycle("R3");
        cycle("R3");
        // R4: rising edge loads
        ab_ck = '1; ba_ck = '1; a_i = 18'h0BEEF; b_i = 18'h3CAFE;
        cycle("R4");
        cycle("R3");

        // R8: channel 0 transparent, channel 1 latched with new data
        ab_le = 2'b01; ba_le = 2'b10; ab_ck = '0; ba_ck = '0;
        a_i = 18'h29C4E; b_i = 18'h1B7D2;
        cycle("R8");
        // R6: enables do not alter storage
        ab_le = '0; ba_le = '0;
        ab_oe_n = 2'b01; ba_oe_n = 2'b10;
        cycle("R6");
        ab_oe_n = '1; ba_oe_n = '1;
        cycle("R6");

        // Constrained random mix
        for (int n = 0; n < 4000; n++) begin
            a_i = DW'($urandom); b_i = DW'($urandom);
            for (int c = 0; c < NCH; c++) begin
                ab_le[c] = ($urandom % 4) == 0;
                ba_le[c] = ($urandom % 4) == 0;
                ab_ck[c] = $urandom % 2;
                ba_ck[c] = $urandom % 2;
                rand_oe(c);
            end
            cycle("");
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule